// File: doc/BRIEF.md
# Signed Adder-Subtractor with Overflow-Aware Display Word

This combinational unit takes two two's-complement operands (5 bits by default, so each lies in −16 … +15) and a mode bit. With the mode bit low it forms A+B. With it high it forms A−B. There is no separate subtractor. The mode bit inverts B bit by bit and is also fed in as the carry into the lowest stage, so a single ripple-carry chain computes A + ~B + 1.

The chain is built from half adders. The lowest stage adds A0 and the conditioned B0 in a half adder. A second half adder then folds in the mode carry, so in subtract mode that stage acts as a full adder. Every upper stage is a full adder made of two half adders.

Validity comes from real signed overflow: the carry into the sign stage is compared with the carry out of it. The raw carry-out alone is not used. The unit also emits a display word that a digit driver can use as it stands. For a valid result the word holds a sign bit and the magnitude. For an overflowed result it holds an all-ones dash code.

Top module: `addsub_unit`

## Requirements
- R1: With sub_mode = 0, sum_o equals (op_a + op_b) modulo 2^W, where W = 5 by default.
- R2: With sub_mode = 1, sum_o equals (op_a − op_b) modulo 2^W, formed as op_a + ~op_b + 1.
- R3: carry_o is bit W of the unsigned sum op_a + (sub_mode ? ~op_b : op_b) + sub_mode. For example, op_b = 0 in subtract mode gives carry_o = 1.
- R4: valid_o is 1 exactly when the mathematical signed result (op_a ± op_b, with both operands read as two's complement) lies in [−2^(W−1), 2^(W−1)−1].
- R5: An addition of two operands of the same sign that leaves the range clears valid_o, whatever carry_o is. Two examples: 15+1 (carry_o = 0) and −8 + −9 (carry_o = 1).
- R6: Subtracting the most negative value is an overflow whenever op_a ≥ 0 (0 − (−16) gives valid_o = 0), and it is valid for op_a < 0 (−1 − (−16) = 15).
- R7: When valid_o = 1, disp_o[W] equals the sign bit of sum_o and disp_o[W−1:0] equals the absolute value of the result as an unsigned number. A result of −16 therefore shows as sign 1 with magnitude 16.
- R8: When valid_o = 0, disp_o is the dash code, all W+1 bits at 1. This value cannot occur for a valid result, because the largest magnitude is 2^(W−1).
- R9: An addition of operands of opposite sign never clears valid_o. For example, −16 + 15 = −1 is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W (5) | First operand, two's complement |
| op_b | input | W (5) | Second operand, two's complement |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| sum_o | output | W (5) | Wrapped W-bit result |
| carry_o | output | 1 | Carry out of the top adder stage |
| valid_o | output | 1 | 1 when the result fits in W signed bits |
| disp_o | output | W+1 (6) | {sign, magnitude} when valid; all ones (dash) when not |

## Verification
Immediate assertions are evaluated whenever the inputs change. They compare the half-adder chain against plain arithmetic for the wrapped sum and the carry. They compare the overflow flag against a range test on a sign-extended exact result. They check that an invalid result always yields the dash word and that a valid display word rebuilds the wrapped sum. The named corner values can only be shown by the bench's scenarios: 15+1 with no carry, 0 − (−16), −1 − (−16), and the magnitude 16 for −16. The bench also sweeps every operand pair in both modes, which covers mixed-sign additions.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int OPERAND_W = 5;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } bit_res_t;

    function automatic bit_res_t half_add(input logic x, input logic y);
        bit_res_t r;
        r.sum   = x ^ y;
        r.carry = x & y;
        return r;
    endfunction

endpackage

// File: rtl/half_adder.sv
module half_adder
    import addsub_pkg::*;
(
    input  logic x_i,
    input  logic y_i,
    output logic s_o,
    output logic c_o
);
    bit_res_t res;

    always_comb begin
        res = half_add(x_i, y_i);
        s_o = res.sum;
        c_o = res.carry;
    end
endmodule

// File: rtl/full_adder.sv
module full_adder (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic s_part;
    logic c_first;
    logic c_second;

    half_adder u_ha_xy (
        .x_i (x_i),
        .y_i (y_i),
        .s_o (s_part),
        .c_o (c_first)
    );

    half_adder u_ha_cin (
        .x_i (s_part),
        .y_i (c_i),
        .s_o (s_o),
        .c_o (c_second)
    );

    assign c_o = c_first | c_second;
endmodule

// File: rtl/operand_cond.sv
module operand_cond
    import addsub_pkg::*;
#(
    parameter int W = OPERAND_W
) (
    input  logic [W-1:0] b_i,
    input  op_mode_e     mode_i,
    output logic [W-1:0] y_o,
    output logic         cin_o
);
    always_comb begin
        y_o   = (mode_i == MODE_SUB) ? ~b_i : b_i;
        cin_o = (mode_i == MODE_SUB);
    end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int W = 5
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] s_o,
    output logic         c_msb_in_o,
    output logic         c_out_o
);
    logic [W:0] carry;

    generate
        for (genvar i = 0; i < W; i++) begin : g_stage
            if (i == 0) begin : g_lsb
                logic s_raw;
                logic c_raw;
                logic c_fold;
                half_adder u_ha_base (
                    .x_i (x_i[0]),
                    .y_i (y_i[0]),
                    .s_o (s_raw),
                    .c_o (c_raw)
                );
                half_adder u_ha_mode (
                    .x_i (s_raw),
                    .y_i (cin_i),
                    .s_o (s_o[0]),
                    .c_o (c_fold)
                );
                assign carry[1] = c_raw | c_fold;
            end else begin : g_upper
                full_adder u_fa (
                    .x_i (x_i[i]),
                    .y_i (y_i[i]),
                    .c_i (carry[i]),
                    .s_o (s_o[i]),
                    .c_o (carry[i+1])
                );
            end
        end
    endgenerate

    assign carry[0]   = cin_i;
    assign c_msb_in_o = carry[W-1];
    assign c_out_o    = carry[W];
endmodule

// File: rtl/result_fmt.sv
module result_fmt #(
    parameter int W = 5
) (
    input  logic [W-1:0] sum_i,
    input  logic         c_msb_in_i,
    input  logic         c_out_i,
    output logic         valid_o,
    output logic [W:0]   disp_o
);
    localparam logic [W:0] DASH_CODE = '1;

    logic         ovf;
    logic [W-1:0] mag;

    always_comb begin
        ovf     = c_msb_in_i ^ c_out_i;
        valid_o = ~ovf;
        mag     = sum_i[W-1] ? (~sum_i + 1'b1) : sum_i;
        disp_o  = valid_o ? {sum_i[W-1], mag} : DASH_CODE;
    end

    always_comb begin
        AST_DASH_ON_OVF: assert (valid_o || disp_o == DASH_CODE); // R8
        AST_DISP_REBUILD: assert (!valid_o ||
            ((disp_o[W] ? (~disp_o[W-1:0] + 1'b1) : disp_o[W-1:0]) == sum_i)); // R7
    end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int W = OPERAND_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_mode,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         valid_o,
    output logic [W:0]   disp_o
);
    localparam int XW = W + 2;

    op_mode_e     mode;
    logic [W-1:0] b_cond;
    logic         cin;
    logic         c_msb_in;

    assign mode = sub_mode ? MODE_SUB : MODE_ADD;

    operand_cond #(.W(W)) u_cond (
        .b_i    (op_b),
        .mode_i (mode),
        .y_o    (b_cond),
        .cin_o  (cin)
    );

    ripple_chain #(.W(W)) u_chain (
        .x_i        (op_a),
        .y_i        (b_cond),
        .cin_i      (cin),
        .s_o        (sum_o),
        .c_msb_in_o (c_msb_in),
        .c_out_o    (carry_o)
    );

    result_fmt #(.W(W)) u_fmt (
        .sum_i      (sum_i_w),
        .c_msb_in_i (c_msb_in),
        .c_out_i    (carry_o),
        .valid_o    (valid_o),
        .disp_o     (disp_o)
    );

    logic [W-1:0] sum_i_w;
    assign sum_i_w = sum_o;

    logic [W-1:0]  ref_wrap;
    logic [XW-1:0] ref_exact;
    logic [W:0]    ref_wide;

    always_comb begin
        ref_wrap  = sub_mode ? (op_a - op_b) : (op_a + op_b);
        ref_exact = sub_mode
            ? ({{2{op_a[W-1]}}, op_a} - {{2{op_b[W-1]}}, op_b})
            : ({{2{op_a[W-1]}}, op_a} + {{2{op_b[W-1]}}, op_b});
        ref_wide  = {1'b0, op_a} + {1'b0, (sub_mode ? ~op_b : op_b)}
                  + {{W{1'b0}}, sub_mode};
        AST_SUM_ARITH: assert (sum_o == ref_wrap); // R1 R2
        AST_CARRY_BIT: assert (carry_o == ref_wide[W]); // R3
        AST_NO_OVERFLOW: assert (valid_o ==
            (ref_exact[XW-1:W-1] == '0 || ref_exact[XW-1:W-1] == '1)); // R4
    end
endmodule

// File: tb/addsub_unit_tb_top.sv
module addsub_unit_tb_top;
    localparam int W = 5;
    localparam int NV = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_mode = 1'b0;
    logic [W-1:0] sum_o;
    logic         carry_o;
    logic         valid_o;
    logic [W:0]   disp_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addsub_unit #(.W(W)) dut_i (
        .op_a     (op_a),
        .op_b     (op_b),
        .sub_mode (sub_mode),
        .sum_o    (sum_o),
        .carry_o  (carry_o),
        .valid_o  (valid_o),
        .disp_o   (disp_o)
    );

    // {a, b, sub}; -16=10, -9=17, -8=18, -1=1F
    localparam logic [10:0] VEC [NV] = '{
        {5'h03, 5'h04, 1'b0},   // R1 3+4
        {5'h0F, 5'h01, 1'b0},   // R5 15+1, no carry
        {5'h18, 5'h17, 1'b0},   // R5 -8+-9, carry
        {5'h10, 5'h0F, 1'b0},   // R9 -16+15
        {5'h10, 5'h1F, 1'b0},   // R5 -16+-1
        {5'h1F, 5'h1F, 1'b0},   // R1 -1+-1
        {5'h08, 5'h07, 1'b0},   // R1 8+7
        {5'h08, 5'h08, 1'b0},   // R5 8+8
        {5'h05, 5'h07, 1'b1},   // R2 5-7
        {5'h00, 5'h10, 1'b1},   // R6 0-(-16)
        {5'h1F, 5'h10, 1'b1},   // R6 -1-(-16)
        {5'h0A, 5'h00, 1'b1},   // R3 b=0 carry 1
        {5'h10, 5'h01, 1'b1},   // R2 -16-1
        {5'h0F, 5'h1F, 1'b1},   // R2 15-(-1)
        {5'h10, 5'h00, 1'b1},   // R7 -16 shows mag 16
        {5'h00, 5'h0F, 1'b1}    // R2 0-15
    };

    task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic s, input string vtag);
        int ai, bi, ex, t;
        logic ev, ec;
        logic [W-1:0] es;
        logic [W:0] ed;
        bit bad;
        ai = $signed(a);
        bi = $signed(b);
        ex = s ? ai - bi : ai + bi;
        ev = (ex >= -16) && (ex <= 15);
        es = W'(ex);
        t  = int'(a) + (s ? (31 - int'(b) + 1) : int'(b));
        ec = (t >= 32);
        ed = ev ? {(ex < 0), W'((ex < 0) ? -ex : ex)} : '1;
        @(negedge clk);
        op_a = a; op_b = b; sub_mode = s;
        #1;
        bad = 1'b0;
        n_vec++;
        if (sum_o !== es) begin
            bad = 1'b1;
            $display("FAIL %s sum a=%0d b=%0d sub=%0d got %h exp %h",
                     s ? "R2" : "R1", ai, bi, s, sum_o, es);
        end
        if (carry_o !== ec) begin
            bad = 1'b1;
            $display("FAIL R3 carry a=%0d b=%0d sub=%0d got %b exp %b",
                     ai, bi, s, carry_o, ec);
        end
        if (valid_o !== ev) begin
            bad = 1'b1;
            $display("FAIL %s valid a=%0d b=%0d sub=%0d got %b exp %b",
                     vtag, ai, bi, s, valid_o, ev);
        end
        if (disp_o !== ed) begin
            bad = 1'b1;
            $display("FAIL %s disp a=%0d b=%0d sub=%0d got %h exp %h",
                     ev ? "R7" : "R8", ai, bi, s, disp_o, ed);
        end
        if (bad) n_bad++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // Reset-time state with zero inputs: R1 sum 0, R7 disp 0
        run_vec(5'h00, 5'h00, 1'b0, "R4");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i][10:6], VEC[i][5:1], VEC[i][0], "R4");
        end

        // Directed corners
        run_vec(5'h0F, 5'h01, 1'b0, "R5");
        run_vec(5'h18, 5'h17, 1'b0, "R5");
        run_vec(5'h00, 5'h10, 1'b1, "R6");
        run_vec(5'h1F, 5'h10, 1'b1, "R6");
        run_vec(5'h10, 5'h0F, 1'b0, "R9");

        // Exhaustive sweep, both modes
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 32; a++) begin
                for (int b = 0; b < 32; b++) begin
                    run_vec(W'(a), W'(b), m[0],
                            (m == 0 && (a[4] != b[4])) ? "R9" : "R4");
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule